// File: doc/BRIEF.md
# Shared Control and Status Register Unit

This unit holds the registers that every processor context shares: a console address and a console data word loaded from an operator panel, one busy flag per context, a bit-addressable mode mask, a condition register, and a free-running real-time counter. The panel strobes, the console run request, and the per-context I/O request and attention lines are asynchronous to the processor clock. Each one passes through a two-flop synchronizer and a rising-edge detector before it changes any state. The busy and mode-mask registers are bit-oriented. A microinstruction write port sets or clears one chosen bit at a time, and the hardware sets busy bits from the synchronized request and attention edges.

The condition register is loaded only by hardware, and only on a minor-cycle strobe. The real-time counter advances on a one-cycle tick enable. It wraps to zero and pulses an overflow output when it wraps. Every register is read through one synchronous read port. The console registers return data only in the console context's slot, and only while a console run request is pending. A successful read of the console data word retires that request.

Top module: `shregs_unit`

## Requirements
- R1: A rising edge on `pnl_addr_ld_i` loads `pnl_addr_i` into the console address register. The new value is in state after the third rising clock edge that follows the input change, and not before it.
- R2: A rising edge on `pnl_data_ld_i` loads `pnl_data_i` into the console data register, with the same three-edge latency as R1.
- R3: A rising edge on `io_req_i[k]` or `io_attn_i[k]` sets busy bit k three clock edges later. The other busy bits are unchanged.
- R4: When `ui_we_i` is high, the bit numbered `ui_idx_i` takes the value of `ui_val_i` at the next edge (1 sets it, 0 clears it). The target is the busy register when `ui_tgt_i`=0 and the mode mask when `ui_tgt_i`=1. All other bits keep their values.
- R5: When a synchronized hardware set and a microinstruction clear hit the same busy bit in one cycle, the bit ends up set.
- R6: The condition register loads `css_data_i` only at an edge where `css_ld_i` and `minor_stb_i` are both high. Either signal alone leaves it unchanged.
- R7: The real-time counter adds one at each edge where `rtc_tick_i` is high and holds otherwise. It wraps from all ones to zero. `rtc_ovf_o` is high for exactly the one cycle after each wrapping edge.
- R8: A read sampled at an edge (`rd_en_i`=1) presents its result on `rd_data_o` and `rd_ok_o` for the following cycle. The data is zero-extended, and the value returned is the register state before that edge. The `rd_sel_i` codes are: 0 console address, 1 console data, 2 busy, 3 mode mask, 4 condition, 5 counter. The non-console codes give `rd_ok_o`=1. Codes 6 and 7, or no read at all, give `rd_ok_o`=0 and data 0.
- R9: A console read (code 0 or 1) succeeds only when `ctx_i` equals the console context (default 7) and a console run request is pending. A run request becomes pending on a synchronized rising edge of `pnl_run_i`. A console read that does not succeed returns `rd_ok_o`=0 and data 0.
- R10: A successful console data read clears the pending run request. A console address read leaves it pending.
- R11: After reset, every register is zero, no run request is pending, and `rd_ok_o` and `rtc_ovf_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| rst_n | input | 1 | Asynchronous active-low reset, deasserted synchronously |
| pnl_addr_i | input | CON_AW | Panel address switches |
| pnl_data_i | input | CON_DW | Panel data switches |
| pnl_addr_ld_i | input | 1 | Asynchronous address load strobe |
| pnl_data_ld_i | input | 1 | Asynchronous data load strobe |
| pnl_run_i | input | 1 | Asynchronous console run request |
| io_req_i | input | N_CTX | Asynchronous I/O request, one per context |
| io_attn_i | input | N_CTX | Asynchronous attention, one per context |
| ui_we_i | input | 1 | Microinstruction bit write enable |
| ui_tgt_i | input | 1 | Write target: 0 busy, 1 mode mask |
| ui_idx_i | input | UI_IW | Bit number to write |
| ui_val_i | input | 1 | Bit value: 1 set, 0 clear |
| minor_stb_i | input | 1 | Minor-cycle strobe |
| css_ld_i | input | 1 | Condition register load request |
| css_data_i | input | CSS_W | Condition register load value |
| rtc_tick_i | input | 1 | Counter tick enable |
| rtc_ovf_o | output | 1 | Counter wrap pulse |
| ctx_i | input | CTX_W | Context owning the current slot |
| rd_en_i | input | 1 | Read request |
| rd_sel_i | input | 3 | Register select code |
| rd_data_o | output | RD_W | Read data |
| rd_ok_o | output | 1 | Read accepted |

## Verification
Each result is due at a different cycle, and the bench waits for that cycle before it samples.

| Result | When it is due |
|---|---|
| Asynchronous strobe or request | In state after the third edge following the input change |
| Microinstruction bit write, condition load, counter tick | After the first edge |
| Read | Returns state as it stood before its own edge |

The bench drives inputs at falling edges and counts falling edges up to the due cycle before it reads. For the console address, it also issues a read one edge early, which must still return the old value. This pins the exact three-edge latency in place. For the same-cycle priority case, the microinstruction clear is placed in the single cycle during which the synchronized edge pulse is active. The counter is checked by counting overflow pulses at every falling edge over runs of known length.

// File: rtl/shregs_pkg.sv
package shregs_pkg;

  typedef enum logic [2:0] {
    SEL_CADDR = 3'd0,
    SEL_CDATA = 3'd1,
    SEL_BUSY  = 3'd2,
    SEL_PMASK = 3'd3,
    SEL_CSS   = 3'd4,
    SEL_RTC   = 3'd5
  } rd_sel_e;

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/shregs_sync.sv
module shregs_sync #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] rise_o
);

  logic [W-1:0] s1_q, s2_q, s3_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= '0;
      s2_q <= '0;
      s3_q <= '0;
    end else begin
      s1_q <= async_i;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  assign rise_o = s2_q & ~s3_q;

  // R3
  rise_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|rise_o) |=> ((rise_o & $past(rise_o)) == '0));

endmodule

// File: rtl/shregs_bitreg.sv
module shregs_bitreg #(
  parameter int W  = 8,
  parameter int IW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [W-1:0]  hw_set_i,
  input  logic          ui_we_i,
  input  logic [IW-1:0] ui_idx_i,
  input  logic          ui_val_i,
  output logic [W-1:0]  q_o
);

  logic [W-1:0] q_q, q_d;

  always_comb begin
    q_d = q_q;
    for (int i = 0; i < W; i++) begin
      if (ui_we_i && (ui_idx_i == IW'(i))) q_d[i] = ui_val_i;
      if (hw_set_i[i])                     q_d[i] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_q <= '0;
    else        q_q <= q_d;
  end

  assign q_o = q_q;

  // R5
  hw_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|hw_set_i) |=> ((q_o & $past(hw_set_i)) == $past(hw_set_i)));

  // R4
  ui_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ui_we_i && !ui_val_i && (int'(ui_idx_i) < W) && (hw_set_i == '0))
      |=> !q_o[$past(ui_idx_i)]);

  // R4
  bits_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ui_we_i && (hw_set_i == '0)) |=> $stable(q_o));

endmodule

// File: rtl/shregs_rtc.sv
module shregs_rtc #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick_i,
  output logic [W-1:0] cnt_o,
  output logic         ovf_o
);

  logic [W-1:0] cnt_q, cnt_d;
  logic         ovf_q, ovf_d;

  always_comb begin
    cnt_d = cnt_q;
    ovf_d = 1'b0;
    if (tick_i) begin
      cnt_d = cnt_q + W'(1);
      ovf_d = (cnt_q == '1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      ovf_q <= ovf_d;
    end
  end

  assign cnt_o = cnt_q;
  assign ovf_o = ovf_q;

  // R7
  rtc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick_i |=> (cnt_o == $past(cnt_o) + W'(1)));

  // R7
  rtc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_i |=> $stable(cnt_o));

  // R7
  rtc_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_o |-> ((cnt_o == '0) && !$past(ovf_o)));

endmodule

// File: rtl/shregs_unit.sv
module shregs_unit
  import shregs_pkg::*;
#(
  parameter int  N_CTX   = 8,
  parameter int  CON_CTX = 7,
  parameter int  CON_AW  = 16,
  parameter int  CON_DW  = 16,
  parameter int  PM_W    = 8,
  parameter int  CSS_W   = 8,
  parameter int  RTC_W   = 16,
  localparam int CTX_W   = $clog2(N_CTX),
  localparam int UI_IW   = $clog2(max2(N_CTX, PM_W)),
  localparam int RD_W    = max2(max2(CON_AW, CON_DW),
                                max2(max2(N_CTX, PM_W), max2(CSS_W, RTC_W)))
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CON_AW-1:0] pnl_addr_i,
  input  logic [CON_DW-1:0] pnl_data_i,
  input  logic              pnl_addr_ld_i,
  input  logic              pnl_data_ld_i,
  input  logic              pnl_run_i,
  input  logic [N_CTX-1:0]  io_req_i,
  input  logic [N_CTX-1:0]  io_attn_i,
  input  logic              ui_we_i,
  input  logic              ui_tgt_i,
  input  logic [UI_IW-1:0]  ui_idx_i,
  input  logic              ui_val_i,
  input  logic              minor_stb_i,
  input  logic              css_ld_i,
  input  logic [CSS_W-1:0]  css_data_i,
  input  logic              rtc_tick_i,
  output logic              rtc_ovf_o,
  input  logic [CTX_W-1:0]  ctx_i,
  input  logic              rd_en_i,
  input  logic [2:0]        rd_sel_i,
  output logic [RD_W-1:0]   rd_data_o,
  output logic              rd_ok_o
);

  localparam int SYNC_W = 2 * N_CTX + 3;

  logic [SYNC_W-1:0] rise;
  logic [N_CTX-1:0]  busy_set, busy_q;
  logic [PM_W-1:0]   pmask_q;
  logic [RTC_W-1:0]  rtc_q;
  logic              rise_aload, rise_dload, rise_run;

  logic [CON_AW-1:0] caddr_q, caddr_d;
  logic [CON_DW-1:0] cdata_q, cdata_d;
  logic [CSS_W-1:0]  css_q, css_d;
  logic              run_q, run_d, run_clr;
  logic [RD_W-1:0]   rdat_q, rdat_d;
  logic              rok_q, rok_d;
  logic              con_ok;

  shregs_sync #(.W(SYNC_W)) sync_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i ({pnl_run_i, pnl_data_ld_i, pnl_addr_ld_i, io_attn_i, io_req_i}),
    .rise_o  (rise)
  );

  assign busy_set   = rise[N_CTX-1:0] | rise[2*N_CTX-1:N_CTX];
  assign rise_aload = rise[2*N_CTX];
  assign rise_dload = rise[2*N_CTX+1];
  assign rise_run   = rise[2*N_CTX+2];

  shregs_bitreg #(.W(N_CTX), .IW(UI_IW)) busy_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .hw_set_i (busy_set),
    .ui_we_i  (ui_we_i && !ui_tgt_i),
    .ui_idx_i (ui_idx_i),
    .ui_val_i (ui_val_i),
    .q_o      (busy_q)
  );

  shregs_bitreg #(.W(PM_W), .IW(UI_IW)) pmask_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .hw_set_i ('0),
    .ui_we_i  (ui_we_i && ui_tgt_i),
    .ui_idx_i (ui_idx_i),
    .ui_val_i (ui_val_i),
    .q_o      (pmask_q)
  );

  shregs_rtc #(.W(RTC_W)) rtc_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick_i (rtc_tick_i),
    .cnt_o  (rtc_q),
    .ovf_o  (rtc_ovf_o)
  );

  assign con_ok = (ctx_i == CTX_W'(CON_CTX)) && run_q;

  always_comb begin
    caddr_d = rise_aload ? pnl_addr_i : caddr_q;
    cdata_d = rise_dload ? pnl_data_i : cdata_q;
    css_d   = (css_ld_i && minor_stb_i) ? css_data_i : css_q;
    rdat_d  = '0;
    rok_d   = 1'b0;
    run_clr = 1'b0;
    if (rd_en_i) begin
      case (rd_sel_i)
        SEL_CADDR: if (con_ok) begin
          rdat_d = RD_W'(caddr_q);
          rok_d  = 1'b1;
        end
        SEL_CDATA: if (con_ok) begin
          rdat_d  = RD_W'(cdata_q);
          rok_d   = 1'b1;
          run_clr = 1'b1;
        end
        SEL_BUSY:  begin rdat_d = RD_W'(busy_q);  rok_d = 1'b1; end
        SEL_PMASK: begin rdat_d = RD_W'(pmask_q); rok_d = 1'b1; end
        SEL_CSS:   begin rdat_d = RD_W'(css_q);   rok_d = 1'b1; end
        SEL_RTC:   begin rdat_d = RD_W'(rtc_q);   rok_d = 1'b1; end
        default:   ;
      endcase
    end
    run_d = rise_run | (run_q & ~run_clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      caddr_q <= '0;
      cdata_q <= '0;
      css_q   <= '0;
      run_q   <= 1'b0;
      rdat_q  <= '0;
      rok_q   <= 1'b0;
    end else begin
      caddr_q <= caddr_d;
      cdata_q <= cdata_d;
      css_q   <= css_d;
      run_q   <= run_d;
      rdat_q  <= rdat_d;
      rok_q   <= rok_d;
    end
  end

  assign rd_data_o = rdat_q;
  assign rd_ok_o   = rok_q;

  // R8
  rd_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en_i |=> (!rd_ok_o && (rd_data_o == '0)));

  // R9
  con_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en_i && (rd_sel_i <= 3'd1) && (ctx_i != CTX_W'(CON_CTX))) |=> !rd_ok_o);

  // R6
  css_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(css_ld_i && minor_stb_i) |=> $stable(css_q));

endmodule

// File: tb/shregs_unit_tb.sv
`timescale 1ns/1ps
module shregs_unit_tb_top;

  localparam int N_CTX = 8;
  localparam int RTC_W = 6;
  localparam int RTC_M = 1 << RTC_W;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] pnl_addr = '0, pnl_data = '0;
  logic        pnl_aload = 0, pnl_dload = 0, pnl_run = 0;
  logic [7:0]  io_req = '0, io_attn = '0;
  logic        ui_we = 0, ui_tgt = 0, ui_val = 0;
  logic [2:0]  ui_idx = '0;
  logic        minor_stb = 0, css_ld = 0;
  logic [7:0]  css_data = '0;
  logic        rtc_tick = 0;
  logic        rtc_ovf;
  logic [2:0]  ctx = '0;
  logic        rd_en = 0;
  logic [2:0]  rd_sel = '0;
  logic [15:0] rd_data;
  logic        rd_ok;

  int nchk = 0, nfail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  shregs_unit #(.RTC_W(RTC_W)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .pnl_addr_i(pnl_addr), .pnl_data_i(pnl_data),
    .pnl_addr_ld_i(pnl_aload), .pnl_data_ld_i(pnl_dload), .pnl_run_i(pnl_run),
    .io_req_i(io_req), .io_attn_i(io_attn),
    .ui_we_i(ui_we), .ui_tgt_i(ui_tgt), .ui_idx_i(ui_idx), .ui_val_i(ui_val),
    .minor_stb_i(minor_stb), .css_ld_i(css_ld), .css_data_i(css_data),
    .rtc_tick_i(rtc_tick), .rtc_ovf_o(rtc_ovf),
    .ctx_i(ctx), .rd_en_i(rd_en), .rd_sel_i(rd_sel),
    .rd_data_o(rd_data), .rd_ok_o(rd_ok)
  );

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  // called at a falling edge; returns at the next falling edge
  task automatic rd(input logic [2:0] sel, input logic [2:0] c,
                    output logic [15:0] d, output logic ok);
    rd_en = 1; rd_sel = sel; ctx = c;
    @(negedge clk);
    rd_en = 0;
    d = rd_data; ok = rd_ok;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  task automatic ui_write(input logic tgt, input int idx, input logic v);
    ui_we = 1; ui_tgt = tgt; ui_idx = 3'(idx); ui_val = v;
    @(negedge clk);
    ui_we = 0;
  endtask

  task automatic run_req();
    pnl_run = 1; settle();
    pnl_run = 0; settle();
  endtask

  initial begin
    #(8 * 100000);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  end

  initial begin
    logic [15:0] d, a, v;
    logic ok;
    logic [7:0] busy_m, pm_m, css_m;
    int cnt_m, wraps;

    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R11 reset state
    chk("R11 rd_ok idle", rd_ok, 0);
    chk("R11 ovf", rtc_ovf, 0);
    for (int s = 2; s <= 5; s++) begin
      rd(3'(s), 3'd0, d, ok);
      chk("R11 reg zero", d, 0);
      chk("R11 ok", ok, 1);
    end
    rd(3'd1, 3'd7, d, ok);
    chk("R11 no run pending", ok, 0);

    // R8 idle and invalid codes
    chk("R8 idle ok low", rd_ok, 0);
    rd(3'd6, 3'd7, d, ok); chk("R8 code6 ok", ok, 0); chk("R8 code6 data", d, 0);
    rd(3'd7, 3'd0, d, ok); chk("R8 code7 ok", ok, 0);

    // R1 R2 R9 R10 console sweep
    for (int i = 0; i < 8; i++) begin
      a = 16'(i * 16'h1357 + 16'h00a5);
      v = ~a ^ 16'(i << 4);
      run_req();
      pnl_addr = a; pnl_aload = 1;
      if (i == 0) begin
        repeat (2) @(negedge clk);
        rd(3'd0, 3'd7, d, ok);
        chk("R1 not before third edge", d, 0);
        rd(3'd0, 3'd7, d, ok);
        chk("R1 at third edge", d, a);
      end else begin
        settle();
      end
      pnl_aload = 0; settle();
      pnl_data = v; pnl_dload = 1; settle();
      pnl_dload = 0; settle();
      rd(3'd0, 3'(i % 7), d, ok);
      chk("R9 wrong slot ok", ok, 0); chk("R9 wrong slot data", d, 0);
      rd(3'd0, 3'd7, d, ok);
      chk("R1 addr ok", ok, 1); chk("R1 addr", d, a);
      rd(3'd0, 3'd7, d, ok);
      chk("R10 addr read keeps run", ok, 1);
      rd(3'd1, 3'd7, d, ok);
      chk("R2 data ok", ok, 1); chk("R2 data", d, v);
      rd(3'd1, 3'd7, d, ok);
      chk("R10 run retired", ok, 0); chk("R10 data zero", d, 0);
    end

    // R3 busy set sweep
    busy_m = '0;
    for (int i = 0; i < N_CTX; i++) begin
      if (i % 2 == 1) io_attn[i] = 1; else io_req[i] = 1;
      settle();
      io_attn = '0; io_req = '0;
      busy_m[i] = 1'b1;
      rd(3'd2, 3'd0, d, ok);
      chk("R3 busy set", d, 16'(busy_m));
      settle();
    end
    // R4 busy clear sweep
    for (int i = 0; i < N_CTX; i++) begin
      ui_write(1'b0, i, 1'b0);
      busy_m[i] = 1'b0;
      rd(3'd2, 3'd0, d, ok);
      chk("R4 busy clear", d, 16'(busy_m));
    end
    ui_write(1'b0, 5, 1'b1);
    rd(3'd2, 3'd0, d, ok); chk("R4 busy ui set", d, 16'h0020);
    rd(3'd3, 3'd0, d, ok); chk("R4 mask untouched", d, 0);
    ui_write(1'b0, 5, 1'b0);

    // R4 mask patterns
    pm_m = '0;
    foreach (pm_m[k]) ; // no-op
    for (int p = 0; p < 6; p++) begin
      logic [7:0] pat;
      pat = 8'(p * 8'h5b + 8'h24);
      if (p == 4) pat = 8'hff;
      if (p == 5) pat = 8'h00;
      for (int b = 0; b < 8; b++) ui_write(1'b1, b, pat[b]);
      pm_m = pat;
      rd(3'd3, 3'd0, d, ok);
      chk("R4 mask pattern", d, 16'(pm_m));
      rd(3'd2, 3'd0, d, ok);
      chk("R4 busy untouched", d, 0);
    end

    // R5 hardware set beats same-cycle clear
    io_req[2] = 1;
    repeat (2) @(negedge clk);
    ui_we = 1; ui_tgt = 0; ui_idx = 3'd2; ui_val = 0;
    @(negedge clk);
    ui_we = 0;
    rd(3'd2, 3'd0, d, ok);
    chk("R5 set wins", d, 16'h0004);
    io_req = '0; settle();
    ui_write(1'b0, 2, 1'b0);
    rd(3'd2, 3'd0, d, ok);
    chk("R5 later clear", d, 0);

    // R6 condition register
    css_m = '0;
    for (int i = 0; i < 5; i++) begin
      css_data = 8'(i * 8'h37 + 8'h11);
      css_ld = 1; minor_stb = 0;
      @(negedge clk);
      css_ld = 0;
      rd(3'd4, 3'd0, d, ok); chk("R6 load without strobe", d, 16'(css_m));
      css_ld = 1; minor_stb = 1;
      @(negedge clk);
      css_ld = 0; css_m = css_data;
      rd(3'd4, 3'd0, d, ok); chk("R6 load", d, 16'(css_m));
      css_data = ~css_data;
      @(negedge clk);
      minor_stb = 0;
      rd(3'd4, 3'd0, d, ok); chk("R6 strobe alone", d, 16'(css_m));
    end

    // R7 counter runs
    cnt_m = 0;
    for (int r = 0; r < 6; r++) begin
      int t;
      int seen;
      case (r)
        0: t = 1; 1: t = 7; 2: t = 62; 3: t = 64; 4: t = 65; default: t = 130;
      endcase
      wraps = (cnt_m + t) / RTC_M;
      seen = 0;
      rtc_tick = 1;
      for (int j = 0; j < t; j++) begin
        @(negedge clk);
        if (j == t - 1) rtc_tick = 0;
        if (rtc_ovf) seen++;
      end
      @(negedge clk);
      if (rtc_ovf) seen++;
      cnt_m = (cnt_m + t) % RTC_M;
      chk("R7 wrap pulses", seen, wraps);
      rd(3'd5, 3'd0, d, ok);
      chk("R7 count", d, 16'(cnt_m));
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

endmodule